// File: doc/BRIEF.md
# Orthogonal Opcode Control Decoder

This block is the purely combinational control decoder for a small 8-bit accumulator CPU. It takes the instruction register and produces every datapath control the execute stage needs. These are the register load enables, the data-bus source, the RAM read and write strobes, the controls of the low- and high-byte address multiplexers, and the X auto-increment strobe. The ALU function code and the branch condition are passed straight through, and their use lies outside this block.

The destination field is a plain 2-to-4 decode. A single 3-bit field carries both the addressing mode and the bus source. How that field is read depends on the instruction group, which is one of ALU/load, store or branch/jump. On stores the RAM is being written, so the low two bits of the field select what is written. On branches only the low two bits matter. On ALU instructions most codes read RAM, and two of them read the immediate byte or the accumulator instead.

Top module: `opdec_top`

## Requirements
- R1: The group comes from ir[7:5]: 110 is store, 111 is branch, and any other value is ALU. The group output is 0 for ALU, 1 for store and 2 for branch. alu_fn always equals ir[7:5] and br_cond always equals ir[4:2].
- R2: In the ALU group exactly one load enable is high, chosen by ir[4:3]: 00 loads X, 01 loads Y, 10 loads the accumulator, 11 loads the output register.
- R3: In the store group the accumulator and output loads stay low. ld_x follows ir[4:3]=00 and ld_y follows ir[4:3]=01. ram_we is high.
- R4: In the branch group all four load enables are low. ram_we is high only in the store group.
- R5: lo_sel equals ir[0] in every group, where 1 selects immediate D and 0 selects X.
- R6: hi_en is low for the branch group and for modes 0 to 3. For any other instruction it is high. When hi_en is high, hi_sel (1=X, 0=Y) is 1 only for mode 7 with a destination other than the output register.
- R7: ALU bus source (encoding 0 RAM, 1 accumulator, 2 input port, 3 immediate): mode 2 selects immediate, mode 3 selects accumulator, and every other mode selects RAM. The input port is never selected.
- R8: The store bus source depends on ir[1:0]: 00 and 11 select the accumulator, 01 selects the input port, and 10 selects immediate. RAM is never selected.
- R9: The branch bus source is RAM when ir[1]=0, immediate for ir[1:0]=10, and the accumulator for ir[1:0]=11.
- R10: ram_oe is high exactly when the bus source is RAM and the group is not store.
- R11: x_inc is high exactly when the group is not branch, ir[4:3]=11, ir[2]=1 and ir[0]=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir | input | 8 | Instruction register |
| group | output | 2 | Group: 0 ALU, 1 store, 2 branch |
| alu_fn | output | 3 | ALU function code, passed through |
| br_cond | output | 3 | Branch condition code, passed through |
| ld_ac | output | 1 | Accumulator load enable |
| ld_x | output | 1 | X register load enable |
| ld_y | output | 1 | Y register load enable |
| ld_out | output | 1 | Output register load enable |
| bus_src | output | 2 | Bus source: 0 RAM, 1 ACC, 2 input, 3 immediate |
| ram_oe | output | 1 | RAM output enable |
| ram_we | output | 1 | RAM write strobe |
| lo_sel | output | 1 | Low address byte: 1 D, 0 X |
| hi_en | output | 1 | High address byte enable (0 forces zero) |
| hi_sel | output | 1 | High address byte: 1 X, 0 Y |
| x_inc | output | 1 | X auto-increment strobe |

## Verification
The embedded assertions check cross-cutting invariants whenever the opcode changes. RAM is never read and written together. At most one load fires. Stores never load the accumulator or the output register. Branches never enable the high address byte. ALU instructions never select the input port. An X increment implies the output destination. Only the bench's exhaustive sweep of all 256 opcodes against a behavioural model can show that each individual encoding lands on the right source, mode and register. In particular, it shows the mode 7 split between X and Y, and the store source map.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int IR_W   = 8;
  localparam int OP_W   = 3;
  localparam int DST_W  = 2;
  localparam int MODE_W = 3;
  localparam int OP_LSB   = IR_W - OP_W;
  localparam int DST_LSB  = MODE_W;
  localparam int MODE_LSB = 0;

  localparam logic [OP_W-1:0] OP_STORE  = 3'b110;
  localparam logic [OP_W-1:0] OP_BRANCH = 3'b111;

  typedef enum logic [1:0] {
    GRP_ALU    = 2'd0,
    GRP_STORE  = 2'd1,
    GRP_BRANCH = 2'd2
  } grp_e;

  typedef enum logic [1:0] {
    SRC_RAM = 2'd0,
    SRC_AC  = 2'd1,
    SRC_IN  = 2'd2,
    SRC_IMM = 2'd3
  } src_e;

  typedef enum logic [DST_W-1:0] {
    DST_X   = 2'd0,
    DST_Y   = 2'd1,
    DST_AC  = 2'd2,
    DST_OUT = 2'd3
  } dst_e;

  function automatic grp_e classify(input logic [OP_W-1:0] op);
    if (op == OP_STORE)       return GRP_STORE;
    else if (op == OP_BRANCH) return GRP_BRANCH;
    else                      return GRP_ALU;
  endfunction

  function automatic src_e pick_source(input grp_e g, input logic [MODE_W-1:0] m);
    src_e s;
    case (g)
      GRP_STORE: begin
        case (m[1:0])
          2'b01:   s = SRC_IN;
          2'b10:   s = SRC_IMM;
          default: s = SRC_AC;
        endcase
      end
      GRP_BRANCH: begin
        if (!m[1])     s = SRC_RAM;
        else if (m[0]) s = SRC_AC;
        else           s = SRC_IMM;
      end
      default: begin
        if (m == 3'd2)      s = SRC_IMM;
        else if (m == 3'd3) s = SRC_AC;
        else                s = SRC_RAM;
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/opdec_group.sv
module opdec_group
  import opdec_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  logic [DST_W-1:0] dst,
  output grp_e             grp,
  output logic [3:0]       loads,
  output logic             we
);
  logic [3:0] dst_hot;
  logic       suppress_ac_out;
  logic       no_loads;

  always_comb begin
    grp = classify(op);
  end

  for (genvar k = 0; k < 4; k++) begin : g_dec
    assign dst_hot[k] = (dst == DST_W'(k));
  end

  assign suppress_ac_out = (grp == GRP_STORE);
  assign no_loads        = (grp == GRP_BRANCH);
  assign we              = (grp == GRP_STORE);

  always_comb begin
    loads = no_loads ? 4'b0000 : dst_hot;
    if (suppress_ac_out) begin
      loads[DST_AC]  = 1'b0;
      loads[DST_OUT] = 1'b0;
    end
  end

  always_comb begin
    AST_LOAD_ONEHOT: assert ($onehot0(loads)); // R2
    AST_STORE_NO_AC_OUT: assert (!(we && (loads[DST_AC] || loads[DST_OUT]))); // R3
    AST_BRANCH_NO_LOAD: assert (!(grp == GRP_BRANCH) || loads == 4'b0000); // R4
  end
endmodule

// File: rtl/opdec_addr.sv
module opdec_addr
  import opdec_pkg::*;
(
  input  grp_e              grp,
  input  logic [DST_W-1:0]  dst,
  input  logic [MODE_W-1:0] mode,
  output logic              lo_sel,
  output logic              hi_en,
  output logic              hi_sel,
  output logic              x_inc
);
  logic dst_is_out;
  logic is_branch;

  assign dst_is_out = (dst == DST_OUT);
  assign is_branch  = (grp == GRP_BRANCH);
  assign lo_sel     = mode[0];
  assign hi_en      = !is_branch && mode[2];
  assign hi_sel     = !is_branch && (mode == 3'd7) && !dst_is_out;
  assign x_inc      = !is_branch && dst_is_out && mode[2] && !mode[0];

  always_comb begin
    AST_BRANCH_HI_ZERO: assert (!is_branch || !hi_en); // R6
    AST_XINC_NEEDS_OUT: assert (!x_inc || dst_is_out); // R11
    AST_XINC_USES_X: assert (!x_inc || (!lo_sel && hi_en && !hi_sel)); // R11
  end
endmodule

// File: rtl/opdec_bus.sv
module opdec_bus
  import opdec_pkg::*;
(
  input  grp_e              grp,
  input  logic [MODE_W-1:0] mode,
  output src_e              src,
  output logic              oe
);
  always_comb begin
    src = pick_source(grp, mode);
  end

  assign oe = (src == SRC_RAM) && (grp != GRP_STORE);

  always_comb begin
    AST_ALU_NO_INPUT: assert (!(grp == GRP_ALU) || src != SRC_IN); // R7
    AST_STORE_NO_RAM: assert (!(grp == GRP_STORE) || src != SRC_RAM); // R8
  end
endmodule

// File: rtl/opdec_top.sv
module opdec_top
  import opdec_pkg::*;
(
  input  logic [7:0] ir,
  output logic [1:0] group,
  output logic [2:0] alu_fn,
  output logic [2:0] br_cond,
  output logic       ld_ac,
  output logic       ld_x,
  output logic       ld_y,
  output logic       ld_out,
  output logic [1:0] bus_src,
  output logic       ram_oe,
  output logic       ram_we,
  output logic       lo_sel,
  output logic       hi_en,
  output logic       hi_sel,
  output logic       x_inc
);
  logic [OP_W-1:0]   op;
  logic [DST_W-1:0]  dst;
  logic [MODE_W-1:0] mode;
  grp_e              grp;
  src_e              src;
  logic [3:0]        loads;

  assign op   = ir[OP_LSB +: OP_W];
  assign dst  = ir[DST_LSB +: DST_W];
  assign mode = ir[MODE_LSB +: MODE_W];

  opdec_group u_group (
    .op(op), .dst(dst), .grp(grp), .loads(loads), .we(ram_we)
  );

  opdec_addr u_addr (
    .grp(grp), .dst(dst), .mode(mode),
    .lo_sel(lo_sel), .hi_en(hi_en), .hi_sel(hi_sel), .x_inc(x_inc)
  );

  opdec_bus u_bus (
    .grp(grp), .mode(mode), .src(src), .oe(ram_oe)
  );

  assign group   = grp;
  assign bus_src = src;
  assign alu_fn  = op;
  assign br_cond = ir[4:2];
  assign ld_x    = loads[DST_X];
  assign ld_y    = loads[DST_Y];
  assign ld_ac   = loads[DST_AC];
  assign ld_out  = loads[DST_OUT];

  always_comb begin
    AST_NO_READ_AND_WRITE: assert (!(ram_oe && ram_we)); // R10
    AST_WE_ONLY_STORE: assert (ram_we == (group == 2'd1)); // R4
  end
endmodule

// File: tb/tb_opdec_top.sv
module tb_opdec_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0] ir = 8'd0;
  logic [1:0] group, bus_src;
  logic [2:0] alu_fn, br_cond;
  logic ld_ac, ld_x, ld_y, ld_out, ram_oe, ram_we, lo_sel, hi_en, hi_sel, x_inc;

  opdec_top dut (
    .ir(ir), .group(group), .alu_fn(alu_fn), .br_cond(br_cond),
    .ld_ac(ld_ac), .ld_x(ld_x), .ld_y(ld_y), .ld_out(ld_out),
    .bus_src(bus_src), .ram_oe(ram_oe), .ram_we(ram_we),
    .lo_sel(lo_sel), .hi_en(hi_en), .hi_sel(hi_sel), .x_inc(x_inc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp, input int op);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s ir=%02h actual=%0d expected=%0d", req, op, act, exp);
    end
  endtask

  task automatic check_all(input int v);
    int top3, d, m, g, src, ldv, e_oe, e_hen, e_hsel, e_xinc;
    top3 = v / 32;
    d = (v / 8) % 4;
    m = v % 8;
    g = (top3 == 6) ? 1 : (top3 == 7) ? 2 : 0;
    // R1 group, pass-through fields
    chk("R1 group", group, g, v);
    chk("R1 alu_fn", alu_fn, top3, v);
    chk("R1 br_cond", br_cond, (v / 4) % 8, v);
    // load vector {out,ac,y,x}
    if (g == 0) ldv = 1 << d;                       // R2
    else if (g == 1) ldv = (d < 2) ? (1 << d) : 0;  // R3
    else ldv = 0;                                   // R4
    chk(g == 0 ? "R2 loads" : (g == 1 ? "R3 loads" : "R4 loads"),
        {ld_out, ld_ac, ld_y, ld_x}, ldv, v);
    chk("R4 ram_we", ram_we, (g == 1) ? 1 : 0, v);
    // R5
    chk("R5 lo_sel", lo_sel, m % 2, v);
    // R6
    e_hen  = (g != 2 && m >= 4) ? 1 : 0;
    e_hsel = (g != 2 && m == 7 && d != 3) ? 1 : 0;
    chk("R6 hi_en", hi_en, e_hen, v);
    if (e_hen == 1) chk("R6 hi_sel", hi_sel, e_hsel, v);
    // bus source: 0 RAM 1 AC 2 IN 3 IMM
    if (g == 0) begin
      src = (m == 2) ? 3 : (m == 3) ? 1 : 0;
      chk("R7 bus_src", bus_src, src, v);
    end else if (g == 1) begin
      case (m % 4) 1: src = 2; 2: src = 3; default: src = 1; endcase
      chk("R8 bus_src", bus_src, src, v);
    end else begin
      src = ((m % 4) < 2) ? 0 : ((m % 4) == 2) ? 3 : 1;
      chk("R9 bus_src", bus_src, src, v);
    end
    e_oe = (src == 0 && g != 1) ? 1 : 0;
    chk("R10 ram_oe", ram_oe, e_oe, v);
    e_xinc = (g != 2 && d == 3 && m >= 4 && (m % 2) == 0) ? 1 : 0;
    chk("R11 x_inc", x_inc, e_xinc, v);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: opcode 00 is an ALU load of X via RAM[0,X]
    chk("R2 reset ld_x", ld_x, 1, 0);
    chk("R10 reset ram_oe", ram_oe, 1, 0);
    for (int i = 0; i < 256; i++) begin
      @(posedge clk);
      #1 ir = 8'(i);
      @(negedge clk);
      check_all(i);
    end
    // directed corners
    @(posedge clk); #1 ir = 8'hDF; @(negedge clk);
    chk("R6 store mode7 OUT uses Y", hi_sel, 0, 8'hDF);
    @(posedge clk); #1 ir = 8'hC7; @(negedge clk);
    chk("R6 store mode7 X dst uses X", hi_sel, 1, 8'hC7);
    @(posedge clk); #1 ir = 8'h1C; @(negedge clk);
    chk("R11 ALU [Y,X++] out", x_inc, 1, 8'h1C);
    @(posedge clk); #1 ir = 8'hFC; @(negedge clk);
    chk("R11 branch no inc", x_inc, 0, 8'hFC);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule